// File: doc/BRIEF.md
# Serial Flash Continuous-Read Responder

This block answers the device side of an SPI mode 0 bus as a page-organised serial flash, but only for continuous array reads. A host lowers chip select and shifts in an 8-bit command. If the command is the continuous read (0xE8), the host then sends a 24-bit start address and 32 don't-care bits. After that, every further serial clock returns one more data bit. An internal counter steps through a built-in byte array, so the host never sends a second address.

The start address is either a page number plus a byte offset for 528-byte pages, or a plain binary address for 512-byte pages. A static mode input selects which. Any other command makes the block stay silent until chip select is raised. All serial lines are sampled in the system clock domain, and the serial clock is detected by its edges.

The states are IDLE, OPCODE, ADDR, DUMMY, DATA and IGNORE. The transitions are:
- IDLE to OPCODE when chip select is low.
- OPCODE to ADDR after 8 bits with a read command.
- OPCODE to IGNORE after 8 bits with any other command.
- ADDR to DUMMY after 24 bits.
- DUMMY to DATA after 32 bits.
- Any state to IDLE when chip select is high.

Top module: `cfr_responder`

## Requirements
- R1: After reset, and on the cycle after chip select is high, `miso_oe` is 0.
- R2: After chip select falls, the first 8 bits sampled on rising serial clock edges form the command, most significant bit first. The value 0xE8 starts a continuous read.
- R3: A read command is followed by 24 address bits (MSB first) and then 32 don't-care bits. `miso_oe` stays 0 through the command, address and don't-care phases.
- R4: With `page528_mode`=1, address bits 22..10 are the page and bits 9..0 are the offset. The start index is (page*528 + offset) mod MEM_DEPTH.
- R5: With `page528_mode`=0, the start index is address bits 21..0, taken mod MEM_DEPTH.
- R6: Data leaves MSB first. Each bit changes only on a falling serial clock edge, and the first bit is driven on the falling edge after the last don't-care bit.
- R7: After every 8 data bits, the read index advances by one with no new address.
- R8: An index step past MEM_DEPTH-1 wraps to 0.
- R9: Any command other than 0xE8 keeps `miso_oe` at 0 for all further clocks until chip select rises. The next transaction then decodes normally.
- R10: Raising chip select in mid-transaction abandons it. The next falling edge restarts command capture.
- R11: The array byte at index i is (i*29 + (i>>8)*7) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| page528_mode | input | 1 | 1 selects 528-byte page addressing, 0 selects binary |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock (mode 0) |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for `miso`; 0 means high impedance |

## Verification
The bench starts reads near the end of the array and checks that they continue at index 0. A design that saturates or runs past the end would return wrong bytes there. It uses 528-byte page addresses whose offset is large, which catches a mapping that multiplies by 512 or concatenates fields. It sends unknown commands followed by many clocks, which would expose a block that falls through into the address phase and drives the bus. It also cuts a read short after 12 bits; a bit counter that is not cleared by chip select would misalign the following command.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_IGNORE
    } cfr_state_e;

    localparam logic [7:0] OP_CONT_READ = 8'hE8;
    localparam int CMD_BITS   = 8;
    localparam int ADDR_BITS  = 24;
    localparam int DUMMY_BITS = 32;

    // R11: array content pattern
    function automatic logic [7:0] cell_value(input logic [31:0] idx);
        logic [31:0] v;
        v = idx * 32'd29 + (idx >> 8) * 32'd7;
        return v[7:0];
    endfunction

endpackage

// File: rtl/cfr_rom.sv
module cfr_rom #(
    parameter int AW = 11
) (
    input  logic [AW-1:0] addr,
    output logic [7:0]    data
);
    import cfr_pkg::*;

    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        assign cells[g] = cell_value(32'(g));
    end

    assign data = cells[addr];

endmodule

// File: rtl/cfr_addr_map.sv
module cfr_addr_map #(
    parameter int AW = 11
) (
    input  logic [23:0]   addr_bits,
    input  logic          mode528,
    output logic [AW-1:0] lin
);
    logic [12:0] page;
    logic [9:0]  offset;
    logic [23:0] full528;

    assign page    = addr_bits[22:10];
    assign offset  = addr_bits[9:0];
    // page*528 = page*512 + page*16
    assign full528 = {2'b00, page, 9'b0} + {7'b0, page, 4'b0} + {14'b0, offset};
    assign lin     = mode528 ? full528[AW-1:0] : addr_bits[AW-1:0];

endmodule

// File: rtl/cfr_responder.sv
module cfr_responder #(
    parameter int MEM_AW = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic page528_mode,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic miso,
    output logic miso_oe
);
    import cfr_pkg::*;

    cfr_state_e state_q, state_d;

    logic              sck_q;
    logic              sck_rise, sck_fall;
    logic [5:0]        bit_cnt;
    logic [23:0]       shift_q;
    logic [23:0]       shift_next;
    logic [MEM_AW-1:0] rd_addr;
    logic [MEM_AW-1:0] start_lin;
    logic [2:0]        byte_bit;
    logic [7:0]        cur_byte;
    logic              miso_q, oe_q;

    assign sck_rise   = sck & ~sck_q & ~cs_n;
    assign sck_fall   = ~sck & sck_q & ~cs_n;
    assign shift_next = {shift_q[22:0], mosi};

    cfr_addr_map #(.AW(MEM_AW)) map_i (
        .addr_bits (shift_next),
        .mode528   (page528_mode),
        .lin       (start_lin)
    );

    cfr_rom #(.AW(MEM_AW)) rom_i (
        .addr (rd_addr),
        .data (cur_byte)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cs_n) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_OPCODE;
                ST_OPCODE: if (sck_rise && bit_cnt == 6'(CMD_BITS - 1))
                               state_d = (shift_next[7:0] == OP_CONT_READ) ? ST_ADDR : ST_IGNORE;
                ST_ADDR:   if (sck_rise && bit_cnt == 6'(ADDR_BITS - 1))
                               state_d = ST_DUMMY;
                ST_DUMMY:  if (sck_rise && bit_cnt == 6'(DUMMY_BITS - 1))
                               state_d = ST_DATA;
                ST_DATA:   state_d = ST_DATA;
                ST_IGNORE: state_d = ST_IGNORE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counters, shifter, read address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q    <= 1'b0;
            bit_cnt  <= '0;
            shift_q  <= '0;
            rd_addr  <= '0;
            byte_bit <= '0;
        end else begin
            sck_q <= sck;
            if (state_q != state_d) begin
                bit_cnt  <= '0;
                byte_bit <= '0;
            end else if (sck_rise) begin
                bit_cnt <= bit_cnt + 6'd1;
            end
            if (sck_rise) shift_q <= shift_next;
            if (state_q == ST_ADDR && state_d == ST_DUMMY) rd_addr <= start_lin;
            if (state_q == ST_DATA && sck_fall) begin
                byte_bit <= byte_bit + 3'd1;
                if (byte_bit == 3'd7) rd_addr <= rd_addr + 1'b1;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miso_q <= 1'b0;
            oe_q   <= 1'b0;
        end else if (cs_n) begin
            oe_q <= 1'b0;
        end else if (state_q == ST_DATA && sck_fall) begin
            oe_q   <= 1'b1;
            miso_q <= cur_byte[~byte_bit];
        end
    end

    assign miso    = miso_q;
    assign miso_oe = oe_q;

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !miso_oe);

    a_r3_header_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPCODE || state_q == ST_ADDR || state_q == ST_DUMMY) |-> !miso_oe);

    a_r6_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(miso));

    a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && sck_fall && byte_bit == 3'd7)
        |=> rd_addr == $past(rd_addr) + 1'b1);

    a_r9_ignore_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE && !cs_n) |=> (state_q == ST_IGNORE && !miso_oe));

endmodule

// File: tb/cfr_responder_tb_top.sv
module cfr_responder_tb_top;

    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic page528_mode = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso, miso_oe;

    int n_checks = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;  // 250 MHz

    cfr_responder #(.MEM_AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .page528_mode(page528_mode),
        .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso), .miso_oe(miso_oe)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog act=%0d exp=<150000", cycles);
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    function automatic int exp_cell(input int i);
        return (i * 29 + (i >> 8) * 7) & 255;  // R11
    endfunction

    function automatic int exp_lin(input int a, input bit m528);
        if (m528) return ((((a >> 10) & 13'h1FFF) * 528) + (a & 1023)) % DEPTH;
        return (a & 22'h3FFFFF) % DEPTH;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic spi_bit(input logic b, output logic so, output logic oe);
        @(negedge clk); mosi = b;
        repeat (2) @(negedge clk);
        so = miso; oe = miso_oe;
        sck = 1'b1;
        repeat (3) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic cs_low();
        @(negedge clk); cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_high();
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // R2 R3: command, address, don't-care phases; then data bytes
    task automatic read_txn(input logic [7:0] op, input int addr, input bit m528,
                            input int nbytes, input string tag);
        logic so, oe;
        bit hdr_oe;
        int base;
        hdr_oe = 0;
        page528_mode = m528;
        cs_low();
        for (int i = 7; i >= 0; i--) begin spi_bit(op[i], so, oe); hdr_oe |= oe; end
        if (op != 8'hE8) begin
            for (int i = 0; i < 56 + nbytes * 8; i++) begin spi_bit($urandom & 1, so, oe); hdr_oe |= oe; end
            check(!hdr_oe, "R9", hdr_oe, 0);
            cs_high();
            return;
        end
        for (int i = 23; i >= 0; i--) begin spi_bit(addr[i], so, oe); hdr_oe |= oe; end
        for (int i = 0; i < 32; i++) begin spi_bit($urandom & 1, so, oe); hdr_oe |= oe; end
        check(!hdr_oe, "R3", hdr_oe, 0);
        base = exp_lin(addr, m528);
        for (int k = 0; k < nbytes; k++) begin
            logic [7:0] got;
            bit oe_all;
            int e;
            oe_all = 1;
            for (int i = 7; i >= 0; i--) begin spi_bit(1'b0, so, oe); got[i] = so; oe_all &= oe; end
            e = exp_cell((base + k) % DEPTH);
            // R6 MSB-first data, R7 auto-increment
            check(oe_all && got == 8'(e), (tag != "") ? tag : (k == 0 ? (m528 ? "R4" : "R5") : "R7"),
                  int'(got), e);
        end
        cs_high();
    endtask

    initial begin
        logic so, oe;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check(miso_oe == 1'b0, "R1", miso_oe, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(miso_oe == 1'b0, "R1", miso_oe, 0);

        // directed mapping cases
        read_txn(8'hE8, 24'h000000, 1'b0, 2, "");
        read_txn(8'hE8, (3 << 10) | 527, 1'b1, 3, "");     // R4 large offset
        read_txn(8'hE8, (5 << 9) | 300, 1'b0, 2, "");       // R5
        // R8 wrap in both modes
        read_txn(8'hE8, DEPTH - 2, 1'b0, 4, "R8");
        read_txn(8'hE8, (3 << 10) | 463, 1'b1, 3, "R8");    // 3*528+463 = 2047
        // R9 unknown command, then a normal read
        read_txn(8'h0B, 24'h000010, 1'b0, 2, "");
        read_txn(8'hE8, 24'h000010, 1'b0, 1, "R9");
        // R10 abort after 12 bits
        page528_mode = 1'b0;
        cs_low();
        for (int i = 0; i < 12; i++) spi_bit(i < 8 ? 1'(8'hE8 >> (7 - i)) : 1'b1, so, oe);
        cs_high();
        read_txn(8'hE8, 24'h000123, 1'b0, 2, "R10");

        // random mix
        for (int t = 0; t < 24; t++) begin
            logic [7:0] op;
            op = ($urandom % 5 == 0) ? 8'($urandom | 1) : 8'hE8;
            read_txn(op, int'($urandom & 24'hFFFFFF), 1'($urandom), 1 + $urandom % 4, "");
        end

        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule